// File: doc/BRIEF.md
# Multi-Page-Size Data Translation Buffer

This block is a fully associative data translation buffer that holds a fixed number of page mappings, 64 by default. Each entry carries its own page size, chosen per entry from 8 KB, 64 KB, 512 KB and 4 MB. A lookup presents a virtual address and a 13-bit context, plus a user flag, a write flag and a no-fault-load flag. All entries are compared in the same cycle. The result is registered and appears on the response outputs in the following cycle. A separate fill port writes entries at a given index. How entries are chosen for refill is left to the surrounding logic.

A match either grants the access and returns a 41-bit physical address, or reports a data fault or a protection trap. When no entry matches, a miss trap is reported. Faults load a fault status register and a fault address register. Both faults and misses load a tag-access register, so that refill software can rebuild the mapping. The control is a two-state machine. ST_IDLE is held while no lookup is requested. ST_RESP is entered from either state on the cycle after a lookup request, and it drives the response valid. When no request follows, the machine moves from ST_RESP back to ST_IDLE. Back-to-back requests keep it in ST_RESP.

Top module: `mpdtlb`

## Requirements
- R1: The page-size code selects the match span. Code 0 gives 8 KB, 1 gives 64 KB, 2 gives 512 KB and 3 gives 4 MB. Virtual address bits below the span are ignored when an entry is compared.
- R2: An entry matches when its valid bit is set, its tag equals the lookup address above the span, and either its global bit is set or its stored context equals the lookup context.
- R3: A granted hit returns a physical address built from two parts. The entry's physical bits supply everything above the span and the lookup address supplies everything below it. The result is 41 bits wide with bits [12:0] forced to zero.
- R4: When several entries match, the entry with the lowest index supplies the result.
- R5: Three fault conditions are checked on a match. A user access to a privileged entry is a privilege fault. A no-fault load to a side-effect entry is a side-effect fault. Any access that is not a no-fault load, made to a no-fault-only entry, is a no-fault-only fault. Any combination of these gives trap code 2 (data fault), with every applicable bit recorded. A hit with none of them gives trap code 0.
- R6: A write to an entry without write permission, when no R5 fault applies, gives trap code 3 (protection).
- R7: A granted hit sets the used bit of the winning entry, which can be read through probe_idx/probe_used. A faulting match leaves it alone, and a fill clears it.
- R8: On trap codes 1, 2 or 3, tag_access loads the lookup address with bits [12:0] replaced by the lookup context.
- R9: On trap codes 2 or 3, fault_addr loads the lookup address and fault_status is written as follows. Bit 0 is valid and is set to 1. Bit 1 is overflow and takes the previous value of bit 0. Bit 2 records the write flag and bit 3 records the no-fault-load flag. Bits 4, 5 and 6 are the privilege, side-effect and no-fault-only fault bits.
- R10: When no entry matches, the result is trap code 1. fault_status and fault_addr keep their values.
- R11: Reset clears every entry, all outputs and the status registers. rsp_valid is high exactly in the cycle after each lookup request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_en | input | 1 | Write the entry at fill_idx |
| fill_idx | input | 6 | Entry index to write |
| fill_va | input | 64 | Virtual tag (bits below the span are ignored) |
| fill_ctx | input | 13 | Entry context |
| fill_pa | input | 41 | Entry physical address |
| fill_size | input | 2 | Page-size code |
| fill_valid | input | 1 | Entry valid |
| fill_global | input | 1 | Match in any context |
| fill_priv | input | 1 | Privileged-only entry |
| fill_wr_ok | input | 1 | Write permitted |
| fill_side | input | 1 | Side-effect page |
| fill_nfo | input | 1 | No-fault-only page |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_ctx | input | 13 | Lookup context |
| lk_user | input | 1 | User-mode access |
| lk_write | input | 1 | Write access |
| lk_nf_load | input | 1 | No-fault load |
| probe_idx | input | 6 | Entry whose used bit is read |
| probe_used | output | 1 | Used bit of the probed entry |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Access granted |
| rsp_pa | output | 41 | Physical address (zero unless granted) |
| rsp_trap | output | 2 | 0 none, 1 miss, 2 data fault, 3 protection |
| fault_status | output | 7 | Fault status register |
| fault_addr | output | 64 | Fault address register |
| tag_access | output | 64 | Tag-access register |

## Verification
Several properties are checked in every response cycle. A granted hit carries no trap and has an 8 KB aligned address. A miss leaves the fault status and fault address stable. Any fault or protection trap marks the status valid, and the overflow bit is set whenever the previous status was already valid. The tag-access context field always follows the requested context. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the choice of page span per entry, the global bypass, lowest-index priority, the exact combination of fault bits, the computed physical address, and the used bits read back through the probe.

// File: rtl/mpdtlb_pkg.sv
package mpdtlb_pkg;

    localparam int BASE_SHIFT = 13;
    localparam int FS_W       = 7;

    localparam int FS_VALID = 0;
    localparam int FS_OVF   = 1;
    localparam int FS_WRITE = 2;
    localparam int FS_NFL   = 3;
    localparam int FS_PRIV  = 4;
    localparam int FS_SIDE  = 5;
    localparam int FS_NFO   = 6;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_MISS  = 2'd1,
        TRAP_FAULT = 2'd2,
        TRAP_PROT  = 2'd3
    } trap_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_e;

    typedef struct packed {
        logic       valid;
        logic       global_m;
        logic       priv;
        logic       wr_ok;
        logic       side;
        logic       nfo;
        logic [1:0] size;
    } attr_t;

    // Keep-mask for the page span: ones above the span.
    function automatic logic [63:0] span_mask(input logic [1:0] sz);
        return ~((64'd1 << (BASE_SHIFT + 3 * int'(sz))) - 64'd1);
    endfunction

endpackage

// File: rtl/mpdtlb_perm.sv
module mpdtlb_perm
    import mpdtlb_pkg::*;
(
    input  attr_t attr,
    input  logic  user,
    input  logic  write,
    input  logic  nf_load,
    output logic  priv_f,
    output logic  side_f,
    output logic  nfo_f,
    output logic  prot_f
);
    logic any_f;

    always_comb begin
        priv_f = attr.priv & user;
        side_f = nf_load & attr.side;
        nfo_f  = ~nf_load & attr.nfo;
        any_f  = priv_f | side_f | nfo_f;
        prot_f = ~any_f & write & ~attr.wr_ok;
    end
endmodule

// File: rtl/mpdtlb_pick.sv
module mpdtlb_pick #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/mpdtlb_entries.sv
module mpdtlb_entries
    import mpdtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 64,
    parameter int PA_W    = 41,
    parameter int CTX_W   = 13,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VA_W-1:0]    fill_va,
    input  logic [CTX_W-1:0]   fill_ctx,
    input  logic [PA_W-1:0]    fill_pa,
    input  attr_t              fill_attr,
    input  logic [VA_W-1:0]    lk_va,
    input  logic [CTX_W-1:0]   lk_ctx,
    input  logic               used_set,
    input  logic [IDX_W-1:0]   used_idx,
    input  logic [IDX_W-1:0]   sel_idx,
    output attr_t              sel_attr,
    output logic [PA_W-1:0]    sel_pa,
    input  logic [IDX_W-1:0]   probe_idx,
    output logic               probe_used,
    output logic [ENTRIES-1:0] hit_vec
);
    logic [VA_W-1:0]  tag_q  [ENTRIES];
    logic [CTX_W-1:0] ctx_q  [ENTRIES];
    logic [PA_W-1:0]  pa_q   [ENTRIES];
    attr_t            attr_q [ENTRIES];
    logic [ENTRIES-1:0] used_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                ctx_q[i]  <= '0;
                pa_q[i]   <= '0;
                attr_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_en && fill_idx == IDX_W'(i)) begin
                    tag_q[i]  <= fill_va;
                    ctx_q[i]  <= fill_ctx;
                    pa_q[i]   <= fill_pa;
                    attr_q[i] <= fill_attr;
                    used_q[i] <= 1'b0;
                end else if (used_set && used_idx == IDX_W'(i)) begin
                    used_q[i] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        logic [63:0] m;
        for (int i = 0; i < ENTRIES; i++) begin
            m = span_mask(attr_q[i].size);
            hit_vec[i] = attr_q[i].valid
                       && (((lk_va ^ tag_q[i]) & m[VA_W-1:0]) == '0)
                       && (attr_q[i].global_m || ctx_q[i] == lk_ctx);
        end
    end

    assign sel_attr   = attr_q[sel_idx];
    assign sel_pa     = pa_q[sel_idx];
    assign probe_used = used_q[probe_idx];
endmodule

// File: rtl/mpdtlb.sv
module mpdtlb
    import mpdtlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VA_W    = 64,
    parameter int PA_W    = 41,
    parameter int CTX_W   = 13,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VA_W-1:0]    fill_va,
    input  logic [CTX_W-1:0]   fill_ctx,
    input  logic [PA_W-1:0]    fill_pa,
    input  logic [1:0]         fill_size,
    input  logic               fill_valid,
    input  logic               fill_global,
    input  logic               fill_priv,
    input  logic               fill_wr_ok,
    input  logic               fill_side,
    input  logic               fill_nfo,
    input  logic               lk_req,
    input  logic [VA_W-1:0]    lk_va,
    input  logic [CTX_W-1:0]   lk_ctx,
    input  logic               lk_user,
    input  logic               lk_write,
    input  logic               lk_nf_load,
    input  logic [IDX_W-1:0]   probe_idx,
    output logic               probe_used,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [PA_W-1:0]    rsp_pa,
    output logic [1:0]         rsp_trap,
    output logic [FS_W-1:0]    fault_status,
    output logic [VA_W-1:0]    fault_addr,
    output logic [VA_W-1:0]    tag_access
);
    attr_t              fill_attr, sel_attr;
    logic [PA_W-1:0]    sel_pa, phys;
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit, grant;
    logic [IDX_W-1:0]   win_idx;
    logic               priv_f, side_f, nfo_f, prot_f;
    trap_e              trap_nx, trap_q;
    logic [FS_W-1:0]    fsr_nx, fsr_q;
    logic [VA_W-1:0]    far_q, tacc_q;
    logic               hit_q;
    logic [PA_W-1:0]    pa_q;
    fsm_e               state_q, state_nx;

    assign fill_attr = '{valid: fill_valid, global_m: fill_global, priv: fill_priv,
                         wr_ok: fill_wr_ok, side: fill_side, nfo: fill_nfo,
                         size: fill_size};

    mpdtlb_entries #(
        .ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .CTX_W(CTX_W), .IDX_W(IDX_W)
    ) u_entries (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_va(fill_va),
        .fill_ctx(fill_ctx), .fill_pa(fill_pa), .fill_attr(fill_attr),
        .lk_va(lk_va), .lk_ctx(lk_ctx),
        .used_set(grant), .used_idx(win_idx),
        .sel_idx(win_idx), .sel_attr(sel_attr), .sel_pa(sel_pa),
        .probe_idx(probe_idx), .probe_used(probe_used),
        .hit_vec(hit_vec)
    );

    mpdtlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .req(hit_vec), .any(any_hit), .idx(win_idx)
    );

    mpdtlb_perm u_perm (
        .attr(sel_attr), .user(lk_user), .write(lk_write), .nf_load(lk_nf_load),
        .priv_f(priv_f), .side_f(side_f), .nfo_f(nfo_f), .prot_f(prot_f)
    );

    always_comb begin
        logic [63:0] m;
        m    = span_mask(sel_attr.size);
        phys = (sel_pa & m[PA_W-1:0]) | (lk_va[PA_W-1:0] & ~m[PA_W-1:0]);
        phys[BASE_SHIFT-1:0] = '0;

        if (!any_hit)                    trap_nx = TRAP_MISS;
        else if (priv_f | side_f | nfo_f) trap_nx = TRAP_FAULT;
        else if (prot_f)                 trap_nx = TRAP_PROT;
        else                             trap_nx = TRAP_NONE;

        grant = lk_req && (trap_nx == TRAP_NONE);

        fsr_nx           = '0;
        fsr_nx[FS_VALID] = 1'b1;
        fsr_nx[FS_OVF]   = fsr_q[FS_VALID];
        fsr_nx[FS_WRITE] = lk_write;
        fsr_nx[FS_NFL]   = lk_nf_load;
        fsr_nx[FS_PRIV]  = priv_f;
        fsr_nx[FS_SIDE]  = side_f;
        fsr_nx[FS_NFO]   = nfo_f;
    end

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = lk_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = lk_req ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            pa_q   <= '0;
            trap_q <= TRAP_NONE;
            fsr_q  <= '0;
            far_q  <= '0;
            tacc_q <= '0;
        end else if (lk_req) begin
            hit_q  <= grant;
            pa_q   <= grant ? phys : '0;
            trap_q <= trap_nx;
            if (trap_nx == TRAP_FAULT || trap_nx == TRAP_PROT) begin
                fsr_q <= fsr_nx;
                far_q <= lk_va;
            end
            if (trap_nx != TRAP_NONE)
                tacc_q <= {lk_va[VA_W-1:CTX_W], lk_ctx};
        end
    end

    assign rsp_valid    = (state_q == ST_RESP);
    assign rsp_hit      = hit_q;
    assign rsp_pa       = pa_q;
    assign rsp_trap     = trap_q;
    assign fault_status = fsr_q;
    assign fault_addr   = far_q;
    assign tag_access   = tacc_q;

    assert_grant_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> rsp_trap == TRAP_NONE);

    assert_pa_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> rsp_pa[BASE_SHIFT-1:0] == '0);

    assert_miss_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_trap == TRAP_MISS |-> $stable(fault_status) && $stable(fault_addr));

    assert_fault_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_trap[1] |-> fault_status[FS_VALID]);

    assert_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_trap[1] && $past(fault_status[FS_VALID]) |-> fault_status[FS_OVF]);

    assert_tag_ctx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_trap != TRAP_NONE |-> tag_access[CTX_W-1:0] == $past(lk_ctx));
endmodule

// File: tb/mpdtlb_tb.sv
`timescale 1ns/1ps
module mpdtlb_tb;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_en = 0;
    logic [5:0]  fill_idx = 0;
    logic [63:0] fill_va = 0;
    logic [12:0] fill_ctx = 0;
    logic [40:0] fill_pa = 0;
    logic [1:0]  fill_size = 0;
    logic fill_valid = 0, fill_global = 0, fill_priv = 0, fill_wr_ok = 0, fill_side = 0, fill_nfo = 0;
    logic        lk_req = 0;
    logic [63:0] lk_va = 0;
    logic [12:0] lk_ctx = 0;
    logic lk_user = 0, lk_write = 0, lk_nf_load = 0;
    logic [5:0]  probe_idx = 0;
    logic        probe_used, rsp_valid, rsp_hit;
    logic [40:0] rsp_pa;
    logic [1:0]  rsp_trap;
    logic [6:0]  fault_status;
    logic [63:0] fault_addr, tag_access;

    always #2 clk = ~clk;

    mpdtlb u_dut (.*);

    int n_chk = 0, n_fail = 0;

    // reference model
    logic [63:0] m_tag [N];
    logic [12:0] m_ctx [N];
    logic [40:0] m_pa  [N];
    logic [1:0]  m_sz  [N];
    bit m_v[N], m_g[N], m_pr[N], m_wr[N], m_se[N], m_nfo[N], m_used[N];
    logic [6:0]  e_fsr = 0;
    logic [63:0] e_far = 0, e_tacc = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                        input logic [40:0] pa, input logic [1:0] sz,
                        input bit v, g, pr, wr, se, nfo);
        @(negedge clk);
        fill_en = 1; fill_idx = 6'(idx); fill_va = va; fill_ctx = ctx; fill_pa = pa;
        fill_size = sz; fill_valid = v; fill_global = g; fill_priv = pr;
        fill_wr_ok = wr; fill_side = se; fill_nfo = nfo;
        @(negedge clk);
        fill_en = 0;
        m_tag[idx] = va; m_ctx[idx] = ctx; m_pa[idx] = pa; m_sz[idx] = sz;
        m_v[idx] = v; m_g[idx] = g; m_pr[idx] = pr; m_wr[idx] = wr;
        m_se[idx] = se; m_nfo[idx] = nfo; m_used[idx] = 0;
    endtask

    function automatic logic [63:0] keep(input logic [1:0] sz);
        return 64'hFFFF_FFFF_FFFF_FFFF << (13 + 3 * int'(sz));
    endfunction

    task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                          input bit user, wr, nf, input string tag);
        int w = -1;
        bit pf = 0, sf = 0, of = 0, pt = 0, hit;
        logic [1:0]  etrap;
        logic [40:0] epa = '0;
        logic [63:0] k;
        for (int i = 0; i < N; i++) begin
            k = keep(m_sz[i]);
            if (w < 0 && m_v[i] && ((va & k) == (m_tag[i] & k)) && (m_g[i] || m_ctx[i] == ctx))
                w = i;
        end
        if (w < 0) etrap = 2'd1;
        else begin
            pf = m_pr[w] & user;
            sf = nf & m_se[w];
            of = !nf & m_nfo[w];
            pt = !(pf | sf | of) & wr & !m_wr[w];
            etrap = (pf | sf | of) ? 2'd2 : pt ? 2'd3 : 2'd0;
        end
        hit = (etrap == 2'd0);
        if (hit) begin
            k = keep(m_sz[w]);
            epa = (m_pa[w] & k[40:0]) | (va[40:0] & ~k[40:0]);
            epa[12:0] = '0;
            m_used[w] = 1;
        end
        if (etrap[1]) begin
            e_fsr = {of, sf, pf, nf, wr, e_fsr[0], 1'b1};
            e_far = va;
        end
        if (etrap != 2'd0) e_tacc = {va[63:13], ctx};

        @(negedge clk);
        lk_req = 1; lk_va = va; lk_ctx = ctx; lk_user = user; lk_write = wr; lk_nf_load = nf;
        @(negedge clk);
        lk_req = 0;
        chk(rsp_valid == 1'b1, "R11 rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_trap == etrap, {tag, " trap"}, 64'(rsp_trap), 64'(etrap));
        chk(rsp_hit == hit && rsp_pa == epa, {tag, " pa"}, 64'(rsp_pa), 64'(epa));
        chk(fault_status == e_fsr && fault_addr == e_far, {tag, " status"},
            64'(fault_status), 64'(e_fsr));
        chk(tag_access == e_tacc, {tag, " tag_access"}, tag_access, e_tacc);
    endtask

    task automatic probe(input int idx, input string tag);
        @(negedge clk);
        probe_idx = 6'(idx);
        #1;
        chk(probe_used == m_used[idx], tag, 64'(probe_used), 64'(m_used[idx]));
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0; m_ctx[i] = '0; m_pa[i] = '0; m_sz[i] = '0;
            m_v[i] = 0; m_g[i] = 0; m_pr[i] = 0; m_wr[i] = 0; m_se[i] = 0; m_nfo[i] = 0; m_used[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(rsp_valid == 0 && fault_status == 0 && tag_access == 0 && fault_addr == 0,
            "R11 reset", 64'(fault_status), 64'd0);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid == 0, "R11 idle", 64'(rsp_valid), 64'd0);

        lookup(64'h0000_0012_3456_7000, 13'd5, 0, 0, 0, "R10 empty miss");
        // R1/R3: 4 MB page, low bits come from VA
        fill(5, 64'h0000_0040_0000_0000, 13'd7, 41'h1_2340_0000, 2'd3, 1, 0, 0, 1, 0, 0);
        lookup(64'h0000_0040_0012_3456, 13'd7, 0, 0, 0, "R1 4MB");
        lookup(64'h0000_0040_003F_E000, 13'd7, 0, 0, 0, "R3 pa");
        lookup(64'h0000_0040_0040_0000, 13'd7, 0, 0, 0, "R1 outside span");
        // R4: overlapping 8 KB entry at lower index
        fill(3, 64'h0000_0040_0000_2000, 13'd7, 41'h0_0ABC_0000, 2'd0, 1, 0, 0, 1, 0, 0);
        lookup(64'h0000_0040_0000_2FFF, 13'd7, 0, 0, 0, "R4 lowest");
        fill(8, 64'h0000_0001_0000_0000, 13'd1, 41'h0_5555_0000, 2'd1, 1, 1, 0, 1, 0, 0);
        lookup(64'h0000_0001_0000_E000, 13'd2, 0, 0, 0, "R2 global");
        fill(9, 64'h0000_0002_0000_0000, 13'd1, 41'h0_6666_0000, 2'd2, 1, 0, 0, 1, 0, 0);
        lookup(64'h0000_0002_0004_0000, 13'd2, 0, 0, 0, "R2 ctx mismatch");
        lookup(64'h0000_0002_0004_0000, 13'd1, 0, 0, 0, "R2 ctx match");
        fill(10, 64'h0000_0003_0000_0000, 13'd1, 41'h0_7777_0000, 2'd0, 1, 0, 1, 1, 0, 1);
        lookup(64'h0000_0003_0000_0000, 13'd1, 1, 0, 0, "R5 priv+nfo");
        fill(11, 64'h0000_0004_0000_0000, 13'd1, 41'h0_8888_0000, 2'd0, 1, 0, 0, 1, 1, 0);
        lookup(64'h0000_0004_0000_0000, 13'd1, 0, 0, 1, "R9 side overflow");
        fill(12, 64'h0000_0005_0000_0000, 13'd1, 41'h0_9999_0000, 2'd0, 1, 0, 0, 0, 0, 0);
        lookup(64'h0000_0005_0000_0000, 13'd1, 0, 1, 0, "R6 prot");
        lookup(64'h0000_0005_0000_0000, 13'd1, 0, 0, 0, "R6 read ok");
        lookup(64'h0000_0099_0000_0000, 13'd3, 0, 0, 0, "R10 miss keeps status");
        probe(5, "R7 used after hit");
        probe(10, "R7 no used after fault");
        fill(5, 64'h0000_0040_0000_0000, 13'd7, 41'h1_2340_0000, 2'd3, 1, 0, 0, 1, 0, 0);
        probe(5, "R7 cleared by fill");

        for (int i = 0; i < N; i++)
            fill(i, 64'(($urandom % 8) << 22) | 64'($urandom & 32'h003F_E000), 13'($urandom % 4),
                 41'({$urandom, $urandom}), 2'($urandom % 4), ($urandom % 10) != 0,
                 ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) < 3,
                 ($urandom % 4) == 0, ($urandom % 7) == 0);
        for (int n = 0; n < 1500; n++) begin
            if ($urandom % 10 == 0) begin
                fill(int'($urandom % N), 64'(($urandom % 8) << 22) | 64'($urandom & 32'h003F_E000),
                     13'($urandom % 4), 41'({$urandom, $urandom}), 2'($urandom % 4),
                     ($urandom % 10) != 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
                     ($urandom % 5) < 3, ($urandom % 4) == 0, ($urandom % 7) == 0);
            end else begin
                int j = int'($urandom % N);
                bit nf = ($urandom % 5) == 0;
                lookup(m_tag[j] ^ 64'($urandom & 32'h001F_FFFF), 13'($urandom % 4),
                       ($urandom % 2) == 1, !nf && ($urandom % 5) < 2, nf, "R5 random");
            end
        end
        for (int i = 0; i < N; i++) probe(i, "R7 random used");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule